// File: doc/BRIEF.md
# DRAM Read/Write Turnaround Scheduler

This block is the mode controller that sits beside the command choosers of a DRAM command multiplexer. It keeps the controller in either a read mode or a write mode, inserts a timed turnaround interval whenever the direction changes, and limits how long one direction may hold the bus while the other has work waiting. It also throttles the activate chooser so that activates are spaced by the row-to-row gap, and the column chooser so that reads and writes are spaced by the column-to-column gap.

Each cycle the block tells the request chooser whether it may pick reads or writes, and tells the command chooser whether it may pick commands and activates. It also sets a two-bit steering select for every phase of the DFI word, which places the column request, the other command, a refresh or a NOP on that phase. Refresh is handled by raising a request to every bank machine, waiting until all of them grant, then issuing the refresh on phase 0 and going back to read mode.

The turnaround intervals come from the parameters. Read to write is the read latency. Write to read is the write-to-read time, plus the write latency rounded up to whole controller cycles, plus the column gap. Both intervals must be at least 2 cycles.

Top module: `dram_turnaround_sched`

## Requirements
- R1: After reset the block is in read mode. The read dwell limit starts out already reached, so a pending write leaves read mode on the first cycle even when reads are also pending.
- R2: Read to write takes exactly READ_LATENCY cycles, counted from the last read-mode cycle to the first write-mode cycle. In the READ_LATENCY-1 cycles between, every steering select is NOP and want_reads, want_writes and want_cmds are all low.
- R3: Read mode is left when write_avail is high and either read_avail is low or the read dwell limit has been reached. A mode is never left for anything but its own turnaround or a refresh.
- R4: Write to read takes exactly T_WTR + ceil(CWL/NPHASES) + T_CCD cycles, and the turnaround cycles are quiet in the same way as in R2.
- R5: While both directions have work pending, write mode lasts exactly WRITE_TIME cycles and read mode lasts exactly READ_TIME cycles.
- R6: While act_pending is high, no mode change starts.
- R7: After an act_issued pulse, want_activates is low for T_RRD-1 cycles and high again in the cycle after those.
- R8: After a col_issued pulse, want_reads and want_writes are low for T_CCD-1 cycles.
- R9: refresh_req follows refresh_valid. From read or write mode a refresh request enters the refresh state, where all want outputs are low. refresh_ready and a REFRESH select on phase 0 appear only once every bit of refresh_grant is high, and read mode follows in the next cycle.
- R10: Phase p's select is steer_sel[2p+1:2p], encoded 0 NOP, 1 command, 2 column request, 3 refresh. In read mode the request goes to RD_PHASE and the command to RDCMD_PHASE. In write mode they go to WR_PHASE and WRCMD_PHASE. All other phases get NOP.
- R11: When the request phase and the command phase are the same phase, a pending activate that is allowed to go goes first. The phase carries the command select and the column request is held back. Once act_pending drops, the phase carries the column request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| read_avail | input | 1 | Some bank machine has a read waiting |
| write_avail | input | 1 | Some bank machine has a write waiting |
| act_pending | input | 1 | Some bank machine has an activate waiting |
| act_issued | input | 1 | Pulse: an activate was issued this cycle |
| col_issued | input | 1 | Pulse: a read or write was issued this cycle |
| refresh_valid | input | 1 | Refresher wants to issue a refresh |
| refresh_grant | input | N_BM | One grant per bank machine |
| want_reads | output | 1 | Request chooser may pick reads |
| want_writes | output | 1 | Request chooser may pick writes |
| want_cmds | output | 1 | Command chooser may pick non-column commands |
| want_activates | output | 1 | Command chooser may pick activates |
| steer_sel | output | 2*NPHASES | Per-phase steering selects |
| refresh_req | output | 1 | Refresh request to all bank machines |
| refresh_ready | output | 1 | Refresh accepted and issued this cycle |

## Verification
The hardest case to reach from the ports is the dwell limit. It only shows when both directions stay pending for a long stretch and the mode has been entered fresh, because the read limit starts already reached. The stimulus holds read_avail and write_avail high straight after reset. This forces an immediate exit from read mode, and the bench then counts write-mode cycles, write-to-read turnaround cycles, read-mode cycles and read-to-write turnaround cycles one after another, telling the modes apart by the steering pattern. A second instance with one phase covers the shared-phase case, where activates must go ahead of column requests.

// File: rtl/dts_pkg.sv
package dts_pkg;
  typedef enum logic [2:0] {
    ST_READ    = 3'd0,
    ST_RTW     = 3'd1,
    ST_WRITE   = 3'd2,
    ST_WTR     = 3'd3,
    ST_REFRESH = 3'd4
  } sched_state_e;

  typedef enum logic [1:0] {
    SEL_NOP     = 2'd0,
    SEL_CMD     = 2'd1,
    SEL_REQ     = 2'd2,
    SEL_REFRESH = 2'd3
  } steer_e;
endpackage

// File: rtl/dts_gap_timer.sv
module dts_gap_timer #(
  parameter int GAP = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic ok
);
  localparam int W = $clog2(GAP + 1);
  localparam logic [W-1:0] LOAD = W'(GAP - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = fire || (cnt_q != '0);
    if (fire)               cnt_d = LOAD;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ok = (cnt_q == '0);
endmodule

// File: rtl/dts_dwell_timer.sv
module dts_dwell_timer #(
  parameter int LIMIT         = 16,
  parameter bit START_EXPIRED = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);
  localparam logic [W-1:0] INIT = START_EXPIRED ? LAST : '0;

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!active)           cnt_d = '0;
    else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    else                   cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= INIT;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == LAST);
endmodule

// File: rtl/dts_steer.sv
module dts_steer
  import dts_pkg::*;
#(
  parameter int NPHASES     = 2,
  parameter int RD_PHASE    = 0,
  parameter int RDCMD_PHASE = 1,
  parameter int WR_PHASE    = 1,
  parameter int WRCMD_PHASE = 0
) (
  input  sched_state_e           state,
  input  logic                   act_first,
  input  logic                   refresh_go,
  output logic [2*NPHASES-1:0]   sel
);
  function automatic steer_e pick(int p, int req_ph, int cmd_ph, logic cmd_wins);
    steer_e s;
    s = SEL_NOP;
    if (p == req_ph && p == cmd_ph) s = cmd_wins ? SEL_CMD : SEL_REQ;
    else if (p == req_ph)           s = SEL_REQ;
    else if (p == cmd_ph)           s = SEL_CMD;
    return s;
  endfunction

  for (genvar p = 0; p < NPHASES; p++) begin : g_phase
    steer_e ph_sel;
    always_comb begin
      unique case (state)
        ST_READ:    ph_sel = pick(p, RD_PHASE, RDCMD_PHASE, act_first);
        ST_WRITE:   ph_sel = pick(p, WR_PHASE, WRCMD_PHASE, act_first);
        ST_REFRESH: ph_sel = (p == 0 && refresh_go) ? SEL_REFRESH : SEL_NOP;
        default:    ph_sel = SEL_NOP;
      endcase
    end
    assign sel[2*p +: 2] = ph_sel;
  end
endmodule

// File: rtl/dram_turnaround_sched.sv
module dram_turnaround_sched
  import dts_pkg::*;
#(
  parameter int NPHASES      = 2,
  parameter int N_BM         = 8,
  parameter int RD_PHASE     = 0,
  parameter int RDCMD_PHASE  = 1,
  parameter int WR_PHASE     = 1,
  parameter int WRCMD_PHASE  = 0,
  parameter int READ_LATENCY = 5,
  parameter int CWL          = 3,
  parameter int T_WTR        = 2,
  parameter int T_CCD        = 1,
  parameter int T_RRD        = 6,
  parameter int READ_TIME    = 32,
  parameter int WRITE_TIME   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  read_avail,
  input  logic                  write_avail,
  input  logic                  act_pending,
  input  logic                  act_issued,
  input  logic                  col_issued,
  input  logic                  refresh_valid,
  input  logic [N_BM-1:0]       refresh_grant,
  output logic                  want_reads,
  output logic                  want_writes,
  output logic                  want_cmds,
  output logic                  want_activates,
  output logic [2*NPHASES-1:0]  steer_sel,
  output logic                  refresh_req,
  output logic                  refresh_ready
);
  localparam int RTW_CYC  = READ_LATENCY;
  localparam int WTR_CYC  = T_WTR + (CWL + NPHASES - 1) / NPHASES + T_CCD;
  localparam int TURN_MAX = (RTW_CYC > WTR_CYC) ? RTW_CYC : WTR_CYC;
  localparam int TW       = $clog2(TURN_MAX + 1);
  localparam logic [TW-1:0] RTW_LOAD = TW'(RTW_CYC - 2);
  localparam logic [TW-1:0] WTR_LOAD = TW'(WTR_CYC - 2);
  localparam bit SHARED_RD = (RD_PHASE == RDCMD_PHASE);
  localparam bit SHARED_WR = (WR_PHASE == WRCMD_PHASE);

  sched_state_e  state_q, state_d;
  logic [TW-1:0] turn_q, turn_d;
  logic          turn_en;
  logic          rd_expired, wr_expired;
  logic          ras_ok, cas_ok;
  logic          all_grant, go_write, go_read;
  logic          in_read, in_write, act_first;

  assign all_grant = &refresh_grant;
  assign in_read   = (state_q == ST_READ);
  assign in_write  = (state_q == ST_WRITE);

  dts_dwell_timer #(.LIMIT(READ_TIME), .START_EXPIRED(1'b1)) u_rd_dwell (
    .clk(clk), .rst_n(rst_n), .active(in_read), .expired(rd_expired));

  dts_dwell_timer #(.LIMIT(WRITE_TIME), .START_EXPIRED(1'b0)) u_wr_dwell (
    .clk(clk), .rst_n(rst_n), .active(in_write), .expired(wr_expired));

  dts_gap_timer #(.GAP(T_RRD)) u_rrd (
    .clk(clk), .rst_n(rst_n), .fire(act_issued), .ok(ras_ok));

  dts_gap_timer #(.GAP(T_CCD)) u_ccd (
    .clk(clk), .rst_n(rst_n), .fire(col_issued), .ok(cas_ok));

  assign go_write = write_avail && (!read_avail || rd_expired) && !act_pending;
  assign go_read  = read_avail && (!write_avail || wr_expired) && !act_pending;

  // next-state process
  always_comb begin
    state_d = state_q;
    turn_d  = turn_q;
    turn_en = 1'b0;
    unique case (state_q)
      ST_READ: begin
        if (refresh_valid) state_d = ST_REFRESH;
        else if (go_write) begin
          state_d = ST_RTW;
          turn_d  = RTW_LOAD;
          turn_en = 1'b1;
        end
      end
      ST_WRITE: begin
        if (refresh_valid) state_d = ST_REFRESH;
        else if (go_read) begin
          state_d = ST_WTR;
          turn_d  = WTR_LOAD;
          turn_en = 1'b1;
        end
      end
      ST_RTW: begin
        if (turn_q == '0) state_d = ST_WRITE;
        else begin
          turn_d  = turn_q - 1'b1;
          turn_en = 1'b1;
        end
      end
      ST_WTR: begin
        if (turn_q == '0) state_d = ST_READ;
        else begin
          turn_d  = turn_q - 1'b1;
          turn_en = 1'b1;
        end
      end
      ST_REFRESH: begin
        if (all_grant) state_d = ST_READ;
      end
      default: state_d = ST_READ;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_READ;
      turn_q  <= '0;
    end else begin
      state_q <= state_d;
      if (turn_en) turn_q <= turn_d;
    end
  end

  assign act_first      = act_pending && ras_ok;
  assign want_cmds      = in_read || in_write;
  assign want_activates = want_cmds && ras_ok;
  assign want_reads     = in_read && cas_ok && !(SHARED_RD && act_first);
  assign want_writes    = in_write && cas_ok && !(SHARED_WR && act_first);
  assign refresh_req    = refresh_valid;
  assign refresh_ready  = (state_q == ST_REFRESH) && all_grant;

  dts_steer #(
    .NPHASES(NPHASES), .RD_PHASE(RD_PHASE), .RDCMD_PHASE(RDCMD_PHASE),
    .WR_PHASE(WR_PHASE), .WRCMD_PHASE(WRCMD_PHASE)
  ) u_steer (
    .state(state_q), .act_first(act_first), .refresh_go(all_grant), .sel(steer_sel));
endmodule

// File: rtl/dts_chk.sv
module dts_chk
  import dts_pkg::*;
#(
  parameter int NPHASES = 2,
  parameter int N_BM    = 8,
  parameter int T_RRD   = 6,
  parameter int T_CCD   = 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input sched_state_e         state_q,
  input logic                 act_pending,
  input logic                 act_issued,
  input logic                 col_issued,
  input logic                 want_reads,
  input logic                 want_writes,
  input logic                 want_cmds,
  input logic                 want_activates,
  input logic [2*NPHASES-1:0] steer_sel,
  input logic [N_BM-1:0]      refresh_grant,
  input logic                 refresh_ready
);
  a_r2_turn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RTW || state_q == ST_WTR) |->
      (steer_sel == '0 && !want_reads && !want_writes && !want_cmds));

  a_r3_read_exit: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_READ |=> (state_q == ST_READ || state_q == ST_RTW || state_q == ST_REFRESH));

  a_r4_write_exit: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_WRITE |=> (state_q == ST_WRITE || state_q == ST_WTR || state_q == ST_REFRESH));

  a_r6_act_holds_read: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READ && act_pending) |=> state_q != ST_RTW);

  a_r6_act_holds_write: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WRITE && act_pending) |=> state_q != ST_WTR);

  a_r7_rrd_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (T_RRD > 1 && act_issued) |=> !want_activates);

  a_r8_ccd_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (T_CCD > 1 && col_issued) |=> (!want_reads && !want_writes));

  a_r9_ready_needs_grants: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_ready |-> &refresh_grant);

  a_r9_refresh_returns_read: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_ready |=> state_q == ST_READ);

  a_r10_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({want_reads, want_writes}));
endmodule

bind dram_turnaround_sched dts_chk #(
  .NPHASES(NPHASES), .N_BM(N_BM), .T_RRD(T_RRD), .T_CCD(T_CCD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .state_q(state_q), .act_pending(act_pending),
  .act_issued(act_issued), .col_issued(col_issued), .want_reads(want_reads),
  .want_writes(want_writes), .want_cmds(want_cmds), .want_activates(want_activates),
  .steer_sel(steer_sel), .refresh_grant(refresh_grant), .refresh_ready(refresh_ready));

// File: tb/dram_turnaround_sched_tb.sv
module dram_turnaround_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NBM  = 8;
  localparam int RL   = 5;
  localparam int CWL  = 3;
  localparam int TWTR = 2;
  localparam int TCCD = 2;
  localparam int TRRD = 6;
  localparam int RT   = 32;
  localparam int WT   = 16;
  localparam int RTW_TURN = RL - 1;
  localparam int WTR_TURN = TWTR + (CWL + 1) / 2 + TCCD - 1;
  localparam logic [3:0] READ_PAT  = 4'b0110;
  localparam logic [3:0] WRITE_PAT = 4'b1001;
  localparam logic [3:0] REF_PAT   = 4'b0011;

  logic clk = 1'b0;
  logic rst_n;
  logic read_avail, write_avail, act_pending, act_issued, col_issued, refresh_valid;
  logic [NBM-1:0] refresh_grant;
  logic want_reads, want_writes, want_cmds, want_activates, refresh_req, refresh_ready;
  logic [3:0] steer_sel;

  logic act_pending1, act_issued1;
  logic want_reads1, want_writes1, want_cmds1, want_activates1, refresh_req1, refresh_ready1;
  logic [1:0] steer_sel1;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_turnaround_sched #(
    .NPHASES(2), .N_BM(NBM), .READ_LATENCY(RL), .CWL(CWL), .T_WTR(TWTR),
    .T_CCD(TCCD), .T_RRD(TRRD), .READ_TIME(RT), .WRITE_TIME(WT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .read_avail(read_avail), .write_avail(write_avail),
    .act_pending(act_pending), .act_issued(act_issued), .col_issued(col_issued),
    .refresh_valid(refresh_valid), .refresh_grant(refresh_grant),
    .want_reads(want_reads), .want_writes(want_writes), .want_cmds(want_cmds),
    .want_activates(want_activates), .steer_sel(steer_sel),
    .refresh_req(refresh_req), .refresh_ready(refresh_ready));

  dram_turnaround_sched #(
    .NPHASES(1), .N_BM(NBM), .RD_PHASE(0), .RDCMD_PHASE(0), .WR_PHASE(0),
    .WRCMD_PHASE(0), .READ_LATENCY(RL), .CWL(CWL), .T_WTR(TWTR),
    .T_CCD(TCCD), .T_RRD(TRRD), .READ_TIME(RT), .WRITE_TIME(WT)
  ) u_dut_1p (
    .clk(clk), .rst_n(rst_n), .read_avail(1'b0), .write_avail(1'b0),
    .act_pending(act_pending1), .act_issued(act_issued1), .col_issued(1'b0),
    .refresh_valid(1'b0), .refresh_grant('0),
    .want_reads(want_reads1), .want_writes(want_writes1), .want_cmds(want_cmds1),
    .want_activates(want_activates1), .steer_sel(steer_sel1),
    .refresh_req(refresh_req1), .refresh_ready(refresh_ready1));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(posedge clk);
    #2;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    read_avail = 0; write_avail = 0; act_pending = 0; act_issued = 0;
    col_issued = 0; refresh_valid = 0; refresh_grant = '0;
    act_pending1 = 0; act_issued1 = 0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    nxt();
  endtask

  task automatic t_reset();
    do_reset();
    settle();
    chk("R1 reset steering is read", steer_sel, READ_PAT);
    chk("R1 reset want_reads", want_reads, 1);
    chk("R1 reset want_writes", want_writes, 0);
    chk("R9 reset refresh_req", refresh_req, 0);
    chk("R9 reset refresh_ready", refresh_ready, 0);
  endtask

  // R1/R2/R4/R5: both directions pending from reset
  task automatic t_turn_and_starve();
    int n;
    do_reset();
    read_avail = 1; write_avail = 1;
    settle();
    chk("R10 read phases", steer_sel, READ_PAT);
    nxt();
    chk("R1 read left at once", steer_sel, 0);
    chk("R2 quiet want_cmds", want_cmds, 0);
    n = 0;
    while (steer_sel == 4'b0 && n < 200) begin n++; nxt(); end
    chk("R2 read to write turnaround cycles", n, RTW_TURN);
    chk("R10 write phases", steer_sel, WRITE_PAT);
    n = 0;
    while (steer_sel == WRITE_PAT && n < 200) begin n++; nxt(); end
    chk("R5 write dwell cycles", n, WT);
    n = 0;
    while (steer_sel == 4'b0 && n < 200) begin n++; nxt(); end
    chk("R4 write to read turnaround cycles", n, WTR_TURN);
    chk("R4 back in read", steer_sel, READ_PAT);
    n = 0;
    while (steer_sel == READ_PAT && n < 200) begin n++; nxt(); end
    chk("R5 read dwell cycles", n, RT);
    chk("R3 read left for turnaround", steer_sel, 0);
    read_avail = 0; write_avail = 0;
  endtask

  task automatic t_act_hold();
    do_reset();
    act_pending = 1; write_avail = 1;
    settle();
    for (int i = 0; i < 6; i++) begin
      chk("R6 activate pending holds read", steer_sel, READ_PAT);
      nxt();
    end
    act_pending = 0;
    settle();
    chk("R6 still read in release cycle", steer_sel, READ_PAT);
    nxt();
    chk("R3 leaves read after release", steer_sel, 0);
    write_avail = 0;
  endtask

  task automatic t_rrd();
    int n;
    do_reset();
    settle();
    chk("R7 activates allowed at rest", want_activates, 1);
    act_issued = 1;
    nxt();
    act_issued = 0;
    settle();
    n = 0;
    while (!want_activates && n < 200) begin n++; nxt(); end
    chk("R7 activate blocked cycles", n, TRRD - 1);
  endtask

  task automatic t_ccd();
    int n;
    do_reset();
    col_issued = 1;
    nxt();
    col_issued = 0;
    settle();
    n = 0;
    while (!want_reads && n < 200) begin n++; nxt(); end
    chk("R8 column blocked cycles", n, TCCD - 1);
  endtask

  task automatic t_refresh();
    do_reset();
    refresh_valid = 1;
    settle();
    chk("R9 refresh_req follows valid", refresh_req, 1);
    nxt();
    chk("R9 refresh state blocks want_cmds", want_cmds, 0);
    chk("R9 refresh state blocks want_reads", want_reads, 0);
    for (int i = 0; i < NBM; i++) begin
      refresh_grant[i] = 1'b1;
      settle();
      if (i < NBM - 1) begin
        chk("R9 partial grants no ready", refresh_ready, 0);
        chk("R9 partial grants all NOP", steer_sel, 0);
        nxt();
      end else begin
        chk("R9 all grants ready", refresh_ready, 1);
        chk("R9 refresh on phase 0", steer_sel, REF_PAT);
      end
    end
    nxt();
    refresh_valid = 0; refresh_grant = '0;
    settle();
    chk("R9 back to read after refresh", steer_sel, READ_PAT);
  endtask

  task automatic t_shared();
    do_reset();
    act_pending1 = 1;
    settle();
    chk("R11 shared phase carries activate", steer_sel1, 1);
    chk("R11 shared phase holds reads", want_reads1, 0);
    nxt();
    act_issued1 = 1; act_pending1 = 0;
    settle();
    chk("R11 shared phase carries request next", steer_sel1, 2);
    chk("R11 reads allowed after activate", want_reads1, 1);
    nxt();
    act_issued1 = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_turn_and_starve();
    t_act_hold();
    t_rrd();
    t_ccd();
    t_refresh();
    t_shared();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule